// File: doc/BRIEF.md
# Programmable Functional Unit Miss Detector

This block is a custom-operation functional unit that sits beside a processor register file. A custom instruction reaches it with an 11-bit function identifier and two register operands. The unit holds the identifier of the one user-defined function currently installed in its logic. When an issued identifier equals that resident identifier, the unit returns a result in the same cycle through a purely combinational path. When they differ, the unit raises a fault instead, so that a trap handler can install the missing function and replay the instruction.

Installing a function uses a load port. The port carries the new identifier and a 2-bit selector that stands in for the configured logic. The unit keeps no data between operations. Only the installed configuration is held, so a processor context switch has nothing to save or restore.

Top module: `pfu_miss_top`

## Requirements
- R1: After reset no function is installed, and every issued custom instruction raises `fault` until the first load.
- R2: When `issueValid` is high and `issueFid` equals the installed identifier, `resValid` is high in that same cycle and `result` carries the installed function of `opA` and `opB` combinationally.
- R3: When `issueValid` is high and `issueFid` differs from the installed identifier, `fault` is high, `resValid` is low, and `result` is zero.
- R4: `resValid` and `fault` are never high together, and both are low in any cycle where `issueValid` is low.
- R5: A load (`loadValid` high) takes effect at the next clock edge. An instruction issued in the same cycle as a load is compared against the previously installed identifier.
- R6: The function selector installed with `loadSel` encodes 0 = `opA + opB` (modulo 2^DATA_W), 1 = `opA ^ opB`, 2 = `opA & ~opB`, 3 = the number of one bits in `opA ^ opB`, zero-extended.
- R7: All 11 identifier bits take part in the compare. An issued identifier that differs from the installed one in any single bit faults, including at the identifiers 0 and 2047.
- R8: The result depends only on the operands and the installed function in the current cycle. Earlier operations, faults and repeated loads of the same identifier do not change it.
- R9: `result` is zero in every cycle where `resValid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| issueValid | input | 1 | A custom instruction is issued this cycle |
| issueFid | input | FID_W | Function identifier carried by the instruction |
| opA | input | DATA_W | First register operand |
| opB | input | DATA_W | Second register operand |
| loadValid | input | 1 | Install a new function at the next edge |
| loadFid | input | FID_W | Identifier of the function being installed |
| loadSel | input | 2 | Function selector being installed (encoding in R6) |
| resValid | output | 1 | Result is valid this cycle |
| result | output | DATA_W | Function result, zero when not valid |
| fault | output | 1 | Identifier mismatch; trap requested |

## Verification
The bench builds the unit with an 8-bit datapath and the full 11-bit identifier. With 8-bit operands, every value of `opA` can be swept against a spread of `opB` values for all four selector encodings, and the sums, XORs, masks and bit counts can be computed exactly in the bench. The identifier width is left at 11 bits, so a single-bit flip of every position and both extreme identifiers are within reach. The bench also covers load-and-issue in the same cycle and issue just after reset.

// File: rtl/pfu_miss_pkg.sv
package pfu_miss_pkg;

  typedef enum logic [1:0] {
    FN_ADD  = 2'd0,
    FN_XOR  = 2'd1,
    FN_ANDN = 2'd2,
    FN_POPX = 2'd3
  } pfuFn_e;

  // Strobes from the control half to the datapath half.
  typedef struct packed {
    logic   enable;
    pfuFn_e fn;
  } pfuStrobe_t;

endpackage

// File: rtl/pfu_miss_ctrl.sv
module pfu_miss_ctrl
  import pfu_miss_pkg::*;
#(
  parameter int FID_W = 11
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             issueValid,
  input  logic [FID_W-1:0] issueFid,
  input  logic             loadValid,
  input  logic [FID_W-1:0] loadFid,
  input  logic [1:0]       loadSel,
  output pfuStrobe_t       strobe,
  output logic             resValid,
  output logic             fault
);

  logic [FID_W-1:0] residentFid;
  pfuFn_e           residentFn;
  logic             residentValid;
  logic             hit;

  // Installed configuration: the only thing held across cycles.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      residentFid   <= '0;
      residentFn    <= FN_ADD;
      residentValid <= 1'b0;
    end else if (loadValid) begin
      residentFid   <= loadFid;
      residentFn    <= pfuFn_e'(loadSel);
      residentValid <= 1'b1;
    end
  end

  always_comb begin
    hit           = residentValid && (issueFid == residentFid);
    resValid      = issueValid && hit;
    fault         = issueValid && !hit;
    strobe.enable = resValid;
    strobe.fn     = residentFn;
  end

endmodule

// File: rtl/pfu_miss_dp.sv
module pfu_miss_dp
  import pfu_miss_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  pfuStrobe_t        strobe,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic [DATA_W-1:0] result
);

  localparam int CNT_W = $clog2(DATA_W + 1);

  logic [DATA_W-1:0] diffBits;
  logic [CNT_W-1:0]  onesCnt;
  logic [DATA_W-1:0] fnOut;

  always_comb begin
    diffBits = opA ^ opB;
    onesCnt  = '0;
    for (int i = 0; i < DATA_W; i++) begin
      onesCnt = onesCnt + CNT_W'(diffBits[i]);
    end
  end

  always_comb begin
    unique case (strobe.fn)
      FN_ADD:  fnOut = opA + opB;
      FN_XOR:  fnOut = diffBits;
      FN_ANDN: fnOut = opA & ~opB;
      FN_POPX: fnOut = DATA_W'(onesCnt);
      default: fnOut = '0;
    endcase
    result = strobe.enable ? fnOut : '0;
  end

endmodule

// File: rtl/pfu_miss_top.sv
module pfu_miss_top
  import pfu_miss_pkg::*;
#(
  parameter int FID_W  = 11,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              issueValid,
  input  logic [FID_W-1:0]  issueFid,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic              loadValid,
  input  logic [FID_W-1:0]  loadFid,
  input  logic [1:0]        loadSel,
  output logic              resValid,
  output logic [DATA_W-1:0] result,
  output logic              fault
);

  pfuStrobe_t strobe;

  pfu_miss_ctrl #(.FID_W(FID_W)) ctrl_i (
    .clk(clk), .rstN(rstN),
    .issueValid(issueValid), .issueFid(issueFid),
    .loadValid(loadValid), .loadFid(loadFid), .loadSel(loadSel),
    .strobe(strobe), .resValid(resValid), .fault(fault)
  );

  pfu_miss_dp #(.DATA_W(DATA_W)) dp_i (
    .strobe(strobe), .opA(opA), .opB(opB), .result(result)
  );

endmodule

// File: rtl/pfu_miss_chk.sv
module pfu_miss_chk #(
  parameter int FID_W  = 11,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              issueValid,
  input logic [FID_W-1:0]  issueFid,
  input logic              loadValid,
  input logic [FID_W-1:0]  loadFid,
  input logic              resValid,
  input logic [DATA_W-1:0] result,
  input logic              fault
);

  logic seenLoad;
  logic [FID_W-1:0] lastLoadFid;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      seenLoad    <= 1'b0;
      lastLoadFid <= '0;
    end else if (loadValid) begin
      seenLoad    <= 1'b1;
      lastLoadFid <= loadFid;
    end
  end

  // R1: nothing can hit before the first load
  a_r1_fault_before_load: assert property (@(posedge clk) disable iff (!rstN)
    (!seenLoad && issueValid) |-> fault);

  // R2: a valid result only comes from an issued instruction
  a_r2_result_needs_issue: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> issueValid);

  // R3: a fault carries no result
  a_r3_fault_zero_result: assert property (@(posedge clk) disable iff (!rstN)
    fault |-> (result == '0) && !resValid);

  // R4: outcomes exclusive, and silent without issue
  a_r4_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(resValid && fault));
  a_r4_idle_silent: assert property (@(posedge clk) disable iff (!rstN)
    !issueValid |-> !resValid && !fault);

  // R5: an issue matching the most recently loaded id hits
  a_r5_load_next_cycle: assert property (@(posedge clk) disable iff (!rstN)
    (seenLoad && !loadValid && issueValid && issueFid == lastLoadFid) |-> resValid);

  // R7: an issue differing from the last loaded id faults
  a_r7_mismatch_faults: assert property (@(posedge clk) disable iff (!rstN)
    (seenLoad && issueValid && issueFid != lastLoadFid) |-> fault);

  // R9: result idle at zero
  a_r9_zero_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    !resValid |-> result == '0);

endmodule

bind pfu_miss_top pfu_miss_chk #(.FID_W(FID_W), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rstN(rstN), .issueValid(issueValid), .issueFid(issueFid),
  .loadValid(loadValid), .loadFid(loadFid), .resValid(resValid),
  .result(result), .fault(fault)
);

// File: tb/pfu_miss_top_tb.sv
module pfu_miss_top_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int FID_W  = 11;
  localparam int DATA_W = 8;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              issueValid = 1'b0;
  logic [FID_W-1:0]  issueFid = '0;
  logic [DATA_W-1:0] opA = '0;
  logic [DATA_W-1:0] opB = '0;
  logic              loadValid = 1'b0;
  logic [FID_W-1:0]  loadFid = '0;
  logic [1:0]        loadSel = '0;
  logic              resValid;
  logic [DATA_W-1:0] result;
  logic              fault;

  int testCount = 0;
  int failCount = 0;
  bit finished = 1'b0;

  pfu_miss_top #(.FID_W(FID_W), .DATA_W(DATA_W)) dut_i (
    .clk(clk), .rstN(rstN), .issueValid(issueValid), .issueFid(issueFid),
    .opA(opA), .opB(opB), .loadValid(loadValid), .loadFid(loadFid),
    .loadSel(loadSel), .resValid(resValid), .result(result), .fault(fault)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [DATA_W-1:0] refFn(int sel, logic [DATA_W-1:0] a,
                                               logic [DATA_W-1:0] b);
    int cnt;
    case (sel)
      0: return DATA_W'((int'(a) + int'(b)) % (1 << DATA_W));
      1: return a ^ b;
      2: return a & ~b;
      default: begin
        cnt = 0;
        for (int i = 0; i < DATA_W; i++) if (a[i] != b[i]) cnt++;
        return DATA_W'(cnt);
      end
    endcase
  endfunction

  task automatic checkOut(string req, logic expV, logic expF, logic [DATA_W-1:0] expR);
    testCount++;
    if (resValid !== expV || fault !== expF || result !== expR) begin
      failCount++;
      $display("FAIL %s: got valid=%0b fault=%0b result=%0h, expected valid=%0b fault=%0b result=%0h",
               req, resValid, fault, result, expV, expF, expR);
    end
  endtask

  // Drive at negedge, sample 1 time unit later (combinational outputs).
  task automatic issue(logic [FID_W-1:0] fid, logic [DATA_W-1:0] a, logic [DATA_W-1:0] b);
    issueValid = 1'b1; issueFid = fid; opA = a; opB = b;
    #1;
  endtask

  task automatic doLoad(logic [FID_W-1:0] fid, int sel);
    @(negedge clk);
    issueValid = 1'b0;
    loadValid = 1'b1; loadFid = fid; loadSel = 2'(sel);
    @(negedge clk);
    loadValid = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      failCount++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("[TB] %0d tests run, %0d failed", testCount + 1, failCount);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state, idle then issue faults for several ids
    issueValid = 1'b0; #1;
    checkOut("R1 idle after reset", 1'b0, 1'b0, '0);
    issue(11'd0, 8'h12, 8'h34);  checkOut("R1 id0 before load", 1'b0, 1'b1, '0);
    issue(11'd2047, 8'hff, 8'h01); checkOut("R1 id2047 before load", 1'b0, 1'b1, '0);

    // R6, R2: sweep every opA against spread opB for each function
    for (int sel = 0; sel < 4; sel++) begin
      doLoad(11'(100 + sel), sel);
      for (int a = 0; a < 256; a++) begin
        for (int b = 0; b < 256; b += 17) begin
          issue(11'(100 + sel), 8'(a), 8'(b));
          checkOut("R6 R2 function sweep", 1'b1, 1'b0, refFn(sel, 8'(a), 8'(b)));
        end
      end
    end

    // R3, R9: mismatch faults with zero result; no issue gives zero
    issue(11'd99, 8'haa, 8'h55);  checkOut("R3 mismatch", 1'b0, 1'b1, '0);
    issueValid = 1'b0; #1;        checkOut("R4 R9 no issue", 1'b0, 1'b0, '0);

    // R7: every single-bit flip at both identifier extremes
    doLoad(11'd0, 1);
    issue(11'd0, 8'hf0, 8'h3c); checkOut("R7 id0 hit", 1'b1, 1'b0, 8'hcc);
    for (int k = 0; k < FID_W; k++) begin
      issue(11'(1 << k), 8'hf0, 8'h3c); checkOut("R7 flip from 0", 1'b0, 1'b1, '0);
    end
    doLoad(11'd2047, 2);
    issue(11'd2047, 8'hf0, 8'h3c); checkOut("R7 id2047 hit", 1'b1, 1'b0, 8'hc0);
    for (int k = 0; k < FID_W; k++) begin
      issue(11'd2047 ^ 11'(1 << k), 8'hf0, 8'h3c); checkOut("R7 flip from 2047", 1'b0, 1'b1, '0);
    end

    // R5: load and issue in the same cycle compare against the old id
    @(negedge clk);
    loadValid = 1'b1; loadFid = 11'd500; loadSel = 2'd0;
    issue(11'd500, 8'h01, 8'h02); checkOut("R5 new id same cycle faults", 1'b0, 1'b1, '0);
    issue(11'd2047, 8'hf0, 8'h3c); checkOut("R5 old id same cycle hits", 1'b1, 1'b0, 8'hc0);
    @(negedge clk);
    loadValid = 1'b0;
    issue(11'd500, 8'h01, 8'h02); checkOut("R5 new id next cycle hits", 1'b1, 1'b0, 8'h03);
    issue(11'd2047, 8'h01, 8'h02); checkOut("R5 old id next cycle faults", 1'b0, 1'b1, '0);

    // R8: no carry-over across cycles, faults, or a repeated identical load
    @(negedge clk);
    issue(11'd500, 8'hff, 8'hff); checkOut("R8 first op", 1'b1, 1'b0, 8'hfe);
    @(negedge clk);
    issue(11'd7, 8'h80, 8'h80);   checkOut("R8 intervening fault", 1'b0, 1'b1, '0);
    doLoad(11'd500, 0);
    issue(11'd500, 8'h10, 8'h20); checkOut("R8 after reload same id", 1'b1, 1'b0, 8'h30);
    @(negedge clk);
    issue(11'd500, 8'h10, 8'h20); checkOut("R8 repeat op same result", 1'b1, 1'b0, 8'h30);

    // R1: reset clears the installed function
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    issue(11'd500, 8'h10, 8'h20); checkOut("R1 after second reset", 1'b0, 1'b1, '0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

endmodule